// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Port

This block is a half-duplex serial port. It drives a shift clock and moves bytes over a data line, least significant bit first. A fixed machine cycle times every action. The cycle has twelve slots, numbered 0 to 11. Each pair of slots forms one of six states. Slot 0 is the first phase of the first state, and slot 11 is the second phase of the sixth state. A counter runs freely and steps through the slots, starting from slot 0 in the first clock period after reset.

Writing a byte to the buffer starts a transmission. The byte goes into a nine-bit register with a marker 1 above its top bit. Each cycle shifts this register once toward bit zero and fills it with zeros from the top. Once the marker sits directly above the last data bit, the register shifts one last time and the transfer ends.

Reception starts when software enables it and the receive flag is clear. The receive register is preset with a single 0 marker and shifts once per cycle. Each shift takes in the bit sampled from the data line earlier in that cycle. When the marker reaches the far end, the register shifts one last time and the byte goes to the read buffer. Each direction raises its own flag, and that flag stays set until software clears it.

Top module: `syncser_port`

## Requirements
- R1: During reset and right after it, `txFlag`, `rxFlag` and `dataOe` read 0, `shiftClk` reads 1 and `bufRdData` reads 0.
- R2: `shiftClk` is 1 whenever no transfer is running. During each data cycle of a transfer it is 0 in slots 4 to 9 and 1 in slots 10, 11, 0, 1, 2 and 3.
- R3: Let C0 be the machine cycle in which `bufWrEn` is sampled high while the port is idle. `dataOe` is 1 exactly in cycles C0+2 to C0+9. Throughout cycle C0+2+k, `dataOut` carries bit k of the written byte.
- R4: `txFlag` reads 0 until the transfer ends. It first reads 1 in slot 0 of cycle C0+10.
- R5: While a transfer is pending or running, in either direction, `bufWrEn` is ignored. The byte on the line, the received byte and the idle state that follows are all unchanged.
- R6: Let C0 be the cycle of the first idle slot in which `rxEnable`=1 and `rxFlag`=0. The shift clock then pulses in cycles C0+2 to C0+9 as in R2, and `dataOe` stays 0.
- R7: During reception, `dataIn` is sampled only in slot 9 of cycle C0+2+k, and that sample becomes bit k of the byte. In slot 0 of cycle C0+10, `rxFlag` first reads 1 and `bufRdData` holds the byte.
- R8: `txFlag` and `rxFlag` stay 1 until their clear input is pulsed. They read 0 in the slot after the clear. While `rxFlag`=1, `rxEnable`=1 starts no reception. Clearing the flag while reception is enabled starts one, timed as in R6.
- R9: If a buffer write and a receive trigger arrive in the same idle slot, the port transmits and does not receive.
- R10: While `rxEnable`=0 and no write arrives, the port stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period per slot |
| rstN | input | 1 | Active-low reset, asynchronous |
| bufWrEn | input | 1 | Buffer write strobe; starts a transmission when the port is idle |
| bufWrData | input | 8 | Byte to transmit |
| bufRdData | output | 8 | Last byte received |
| rxEnable | input | 1 | Receive enable |
| txFlagClr | input | 1 | Clears the transmit-done flag |
| rxFlagClr | input | 1 | Clears the receive-done flag |
| txFlag | output | 1 | Transmit-done flag, sticky |
| rxFlag | output | 1 | Receive-done flag, sticky |
| dataOut | output | 1 | Serial data driven onto the line |
| dataOe | output | 1 | Output enable for the data line; the line is released when 0 |
| dataIn | input | 1 | Serial data read from the line |
| shiftClk | output | 1 | Shift clock, idles high |

## Verification
The assertions assume that reset starts the slot counter at slot 0. Under that assumption, every clock fall, clock rise and flag set falls on a fixed slot of the cycle. They also assume that software clears a flag only with an explicit one-slot pulse. The bench drives all inputs on falling edges and holds each write or clear for a single slot, so every input is sampled in exactly one known slot. On the data line, the bench presents the correct bit only in slot 9 and the inverted bit in every other slot. This leaves the sampling slot as the only place where the received value can come from.

// File: rtl/sps_pkg.sv
package sps_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_WAIT,
    SEQ_ARM,
    SEQ_RUN
  } seqState_t;

  // strobes from control to datapath, one cycle wide each
  typedef struct packed {
    logic txLoad;
    logic txShift;
    logic rxLoad;
    logic rxSample;
    logic rxShift;
    logic rxCommit;
  } dpStrobe_t;

endpackage

// File: rtl/sps_phase_gen.sv
module sps_phase_gen #(
  parameter int SLOTS = 12,
  parameter int PH_W  = $clog2(SLOTS)
) (
  input  logic            clk,
  input  logic            rstN,
  output logic [PH_W-1:0] phase,
  output logic            lastSlot
);

  localparam logic [PH_W-1:0] PH_LAST = PH_W'(SLOTS - 1);

  assign lastSlot = (phase == PH_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= '0;
    end else if (lastSlot) begin
      phase <= '0;
    end else begin
      phase <= phase + PH_W'(1);
    end
  end

endmodule

// File: rtl/sps_ctrl.sv
module sps_ctrl
  import sps_pkg::*;
#(
  parameter int SLOTS         = 12,
  parameter int PH_W          = $clog2(SLOTS),
  parameter int CLK_LOW_FIRST = 4,
  parameter int CLK_LOW_LAST  = 9,
  parameter int SAMPLE_SLOT   = 9
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PH_W-1:0] phase,
  input  logic            lastSlot,
  input  logic            wrReq,
  input  logic            rxEnable,
  input  logic            txClr,
  input  logic            rxClr,
  input  logic            txDone,
  input  logic            rxDone,
  output dpStrobe_t       strobe,
  output logic            running,
  output logic            dirTx,
  output logic            txFlag,
  output logic            rxFlag,
  output logic            shiftClk
);

  localparam int NFLAG = 2;
  localparam logic [PH_W-1:0] PH_LOW_A = PH_W'(CLK_LOW_FIRST);
  localparam logic [PH_W-1:0] PH_LOW_B = PH_W'(CLK_LOW_LAST);
  localparam logic [PH_W-1:0] PH_SMPL  = PH_W'(SAMPLE_SLOT);

  seqState_t seq;
  logic wrAccept, rxTrig, runTx, runRx;
  logic txFinish, rxFinish;
  logic [NFLAG-1:0] flagSet, flagClr, flagQ;

  always_comb begin
    wrAccept = wrReq && (seq == SEQ_IDLE);
    rxTrig   = !wrReq && (seq == SEQ_IDLE) && rxEnable && !flagQ[1];
    runTx    = (seq == SEQ_RUN) && dirTx;
    runRx    = (seq == SEQ_RUN) && !dirTx;

    strobe.txLoad   = wrAccept;
    strobe.txShift  = runTx && lastSlot;
    strobe.rxLoad   = (seq == SEQ_ARM) && !dirTx && lastSlot;
    strobe.rxSample = runRx && (phase == PH_SMPL);
    strobe.rxShift  = runRx && lastSlot;
    strobe.rxCommit = runRx && lastSlot && rxDone;

    txFinish = runTx && lastSlot && txDone;
    rxFinish = runRx && lastSlot && rxDone;
  end

  // sequencer: wait for the end of the start cycle, spend one full
  // preparation cycle, then run one data cycle per bit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seq   <= SEQ_IDLE;
      dirTx <= 1'b0;
    end else begin
      unique case (seq)
        SEQ_IDLE: begin
          if (wrAccept || rxTrig) begin
            dirTx <= wrAccept;
            seq   <= lastSlot ? SEQ_ARM : SEQ_WAIT;
          end
        end
        SEQ_WAIT: if (lastSlot) seq <= SEQ_ARM;
        SEQ_ARM:  if (lastSlot) seq <= SEQ_RUN;
        SEQ_RUN:  if (txFinish || rxFinish) seq <= SEQ_IDLE;
        default:  seq <= SEQ_IDLE;
      endcase
    end
  end

  assign flagSet = {rxFinish, txFinish};
  assign flagClr = {rxClr, txClr};

  // sticky done flags, set wins over a simultaneous clear
  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        flagQ[i] <= 1'b0;
      end else if (flagSet[i]) begin
        flagQ[i] <= 1'b1;
      end else if (flagClr[i]) begin
        flagQ[i] <= 1'b0;
      end
    end
  end

  assign txFlag   = flagQ[0];
  assign rxFlag   = flagQ[1];
  assign running  = (seq == SEQ_RUN);
  assign shiftClk = !(running && (phase >= PH_LOW_A) && (phase <= PH_LOW_B));

endmodule

// File: rtl/sps_datapath.sv
module sps_datapath
  import sps_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              dataIn,
  output logic              txBit,
  output logic              txDone,
  output logic              rxDone,
  output logic [DATA_W-1:0] rxBuf
);

  localparam int TX_W = DATA_W + 1;
  localparam logic [DATA_W-1:0] TX_END  = DATA_W'(1);
  localparam logic [DATA_W-1:0] RX_INIT = {1'b0, {(DATA_W-1){1'b1}}};

  logic [TX_W-1:0]   txReg;
  logic [DATA_W-1:0] rxReg;
  logic              sampleBit;

  // transmit: marker 1 above the byte, zeros enter from the top
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txReg <= '0;
    end else if (strobe.txLoad) begin
      txReg <= {1'b1, wrData};
    end else if (strobe.txShift) begin
      txReg <= {1'b0, txReg[TX_W-1:1]};
    end
  end

  assign txBit  = txReg[0];
  assign txDone = (txReg[TX_W-1:1] == TX_END);

  // receive: a single 0 marker walks down as samples enter from the top
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampleBit <= 1'b0;
    end else if (strobe.rxSample) begin
      sampleBit <= dataIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxReg <= '1;
    end else if (strobe.rxLoad) begin
      rxReg <= RX_INIT;
    end else if (strobe.rxShift) begin
      rxReg <= {sampleBit, rxReg[DATA_W-1:1]};
    end
  end

  assign rxDone = !rxReg[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxBuf <= '0;
    end else if (strobe.rxCommit) begin
      rxBuf <= {sampleBit, rxReg[DATA_W-1:1]};
    end
  end

endmodule

// File: rtl/syncser_port.sv
module syncser_port
  import sps_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int SLOTS         = 12,
  parameter int CLK_LOW_FIRST = 4,
  parameter int CLK_LOW_LAST  = 9,
  parameter int SAMPLE_SLOT   = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bufWrEn,
  input  logic [DATA_W-1:0] bufWrData,
  output logic [DATA_W-1:0] bufRdData,
  input  logic              rxEnable,
  input  logic              txFlagClr,
  input  logic              rxFlagClr,
  output logic              txFlag,
  output logic              rxFlag,
  output logic              dataOut,
  output logic              dataOe,
  input  logic              dataIn,
  output logic              shiftClk
);

  localparam int PH_W = $clog2(SLOTS);

  logic [PH_W-1:0] phase;
  logic            lastSlot;
  dpStrobe_t       strobe;
  logic            running, dirTx, txDone, rxDone, txBit;

  sps_phase_gen #(.SLOTS(SLOTS), .PH_W(PH_W)) u_phase (
    .clk      (clk),
    .rstN     (rstN),
    .phase    (phase),
    .lastSlot (lastSlot)
  );

  sps_ctrl #(
    .SLOTS         (SLOTS),
    .PH_W          (PH_W),
    .CLK_LOW_FIRST (CLK_LOW_FIRST),
    .CLK_LOW_LAST  (CLK_LOW_LAST),
    .SAMPLE_SLOT   (SAMPLE_SLOT)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .phase    (phase),
    .lastSlot (lastSlot),
    .wrReq    (bufWrEn),
    .rxEnable (rxEnable),
    .txClr    (txFlagClr),
    .rxClr    (rxFlagClr),
    .txDone   (txDone),
    .rxDone   (rxDone),
    .strobe   (strobe),
    .running  (running),
    .dirTx    (dirTx),
    .txFlag   (txFlag),
    .rxFlag   (rxFlag),
    .shiftClk (shiftClk)
  );

  sps_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wrData (bufWrData),
    .dataIn (dataIn),
    .txBit  (txBit),
    .txDone (txDone),
    .rxDone (rxDone),
    .rxBuf  (bufRdData)
  );

  assign dataOe  = running && dirTx;
  assign dataOut = txBit;

endmodule

// File: rtl/sps_checker.sv
module sps_checker #(
  parameter int SLOTS     = 12,
  parameter int LOW_FIRST = 4,
  parameter int LOW_LAST  = 9,
  parameter int PH_W      = $clog2(SLOTS)
) (
  input logic            clk,
  input logic            rstN,
  input logic [PH_W-1:0] phase,
  input logic            shiftClk,
  input logic            dataOe,
  input logic            dataOut,
  input logic            txFlag,
  input logic            rxFlag,
  input logic            txFlagClr,
  input logic            rxFlagClr
);

  localparam logic [PH_W-1:0] PH_FALL = PH_W'(LOW_FIRST);
  localparam logic [PH_W-1:0] PH_RISE = PH_W'(LOW_LAST + 1);

  a_r2_fall_slot: assert property (@(posedge clk) disable iff (!rstN)
    $fell(shiftClk) |-> (phase == PH_FALL));

  a_r2_rise_slot: assert property (@(posedge clk) disable iff (!rstN)
    $rose(shiftClk) |-> (phase == PH_RISE));

  a_r3_oe_cycle_edge: assert property (@(posedge clk) disable iff (!rstN)
    (phase != '0) |-> $stable(dataOe));

  a_r3_data_hold: assert property (@(posedge clk) disable iff (!rstN)
    (dataOe && phase != '0) |-> $stable(dataOut));

  a_r4_ti_slot: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txFlag) |-> (phase == '0));

  a_r7_ri_slot: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxFlag) |-> (phase == '0));

  a_r8_ti_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (txFlag && !txFlagClr) |=> txFlag);

  a_r8_ri_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (rxFlag && !rxFlagClr) |=> rxFlag);

endmodule

bind syncser_port sps_checker u_sps_checker (
  .clk       (clk),
  .rstN      (rstN),
  .phase     (phase),
  .shiftClk  (shiftClk),
  .dataOe    (dataOe),
  .dataOut   (dataOut),
  .txFlag    (txFlag),
  .rxFlag    (rxFlag),
  .txFlagClr (txFlagClr),
  .rxFlagClr (rxFlagClr)
);

// File: tb/test_syncser_port.sv
`timescale 1ns/1ps
module test_syncser_port;

  logic clk = 1'b0;
  logic rstN, bufWrEn, rxEnable, txFlagClr, rxFlagClr, dataIn;
  logic [7:0] bufWrData, bufRdData;
  logic txFlag, rxFlag, dataOut, dataOe, shiftClk;

  int slot;
  int nChk = 0;
  int nBad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  syncser_port i_syncser_port (
    .clk       (clk),
    .rstN      (rstN),
    .bufWrEn   (bufWrEn),
    .bufWrData (bufWrData),
    .bufRdData (bufRdData),
    .rxEnable  (rxEnable),
    .txFlagClr (txFlagClr),
    .rxFlagClr (rxFlagClr),
    .txFlag    (txFlag),
    .rxFlag    (rxFlag),
    .dataOut   (dataOut),
    .dataOe    (dataOe),
    .dataIn    (dataIn),
    .shiftClk  (shiftClk)
  );

  // slot of the period following each rising edge, per R2
  always @(posedge clk) begin
    if (!rstN) slot <= 0;
    else       slot <= (slot == 11) ? 0 : slot + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h (slot %0d)", req, act, exp, slot);
    end
  endtask

  task automatic waitSlot(input int s);
    do @(negedge clk); while (slot != s);
  endtask

  task automatic idleCheck(input int n, input string req);
    repeat (n) begin
      @(negedge clk);
      chk(req, int'(dataOe), 0);
      chk(req, int'(shiftClk), 1);
    end
  endtask

  // transmit one byte; write in slot ws of cycle C0
  task automatic runTx(input logic [7:0] d, input int ws, input bit inject,
                       input bit pulseRx, input int holdSlots);
    int m;
    bit oeExp;
    string tag;
    tag = inject ? "R5 busy write" : "R3 tx";
    waitSlot(ws);
    bufWrData = d;
    bufWrEn   = 1'b1;
    rxEnable  = pulseRx;
    m = 0;
    while (1) begin
      @(negedge clk);
      bufWrEn  = 1'b0;
      rxEnable = 1'b0;
      if (slot == 0) m++;
      if (inject && m == 4 && slot == 3) begin
        bufWrEn   = 1'b1;
        bufWrData = ~d;
      end
      oeExp = (m >= 2) && (m <= 9);
      chk({tag, " oe"}, int'(dataOe), int'(oeExp));
      if (oeExp) chk({tag, " data"}, int'(dataOut), int'(d[m-2]));
      chk("R2 shift clock", int'(shiftClk), int'(!(oeExp && slot >= 4 && slot <= 9)));
      chk("R4 tx flag", int'(txFlag), int'(m >= 10));
      if (m == 10) break;
    end
    if (pulseRx) chk("R9 no reception", int'(rxFlag), 0);
    repeat (holdSlots) begin
      @(negedge clk);
      chk("R8 tx flag sticky", int'(txFlag), 1);
    end
    @(negedge clk);
    txFlagClr = 1'b1;
    @(negedge clk);
    txFlagClr = 1'b0;
    chk("R8 tx flag clear", int'(txFlag), 0);
  endtask

  // receive one byte; enable in slot ts of cycle C0
  task automatic runRx(input logic [7:0] d, input int ts, input bit inject,
                       input bit keepFlag);
    int m;
    bit act;
    waitSlot(ts);
    rxEnable = 1'b1;
    m = 0;
    while (1) begin
      @(negedge clk);
      bufWrEn = 1'b0;
      if (slot == 0) m++;
      act = (m >= 2) && (m <= 9);
      dataIn = act ? ((slot == 9) ? d[m-2] : ~d[m-2]) : 1'b0;
      if (inject && m == 5 && slot == 2) begin
        bufWrEn   = 1'b1;
        bufWrData = ~d;
      end
      chk(inject ? "R5 write during rx" : "R6 line released", int'(dataOe), 0);
      chk("R6 shift clock", int'(shiftClk), int'(!(act && slot >= 4 && slot <= 9)));
      chk("R7 rx flag", int'(rxFlag), int'(m >= 10));
      if (m == 10) begin
        chk("R7 rx byte", int'(bufRdData), int'(d));
        break;
      end
    end
    if (!keepFlag) begin
      rxEnable = 1'b0;
      @(negedge clk);
      rxFlagClr = 1'b1;
      @(negedge clk);
      rxFlagClr = 1'b0;
      chk("R8 rx flag clear", int'(rxFlag), 0);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
  endtask

  initial begin
    int m;
    bit act;
    rstN = 1'b0; bufWrEn = 1'b0; bufWrData = '0; rxEnable = 1'b0;
    txFlagClr = 1'b0; rxFlagClr = 1'b0; dataIn = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset txFlag", int'(txFlag), 0);
    chk("R1 reset rxFlag", int'(rxFlag), 0);
    chk("R1 reset oe", int'(dataOe), 0);
    chk("R1 reset clk", int'(shiftClk), 1);
    chk("R1 reset buffer", int'(bufRdData), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after reset flags", int'(txFlag | rxFlag), 0);
    chk("R1 after reset buffer", int'(bufRdData), 0);
    idleCheck(30, "R10 idle");

    for (int d = 0; d < 256; d++) runTx(8'(d), d % 12, 1'b0, 1'b0, 0);
    runTx(8'hA5, 3, 1'b1, 1'b0, 0);
    idleCheck(30, "R5 no extra transfer");
    runTx(8'h5A, 7, 1'b0, 1'b1, 0);
    idleCheck(30, "R9 idle after tx");
    runTx(8'h81, 11, 1'b0, 1'b0, 40);

    for (int d = 0; d < 256; d++) runRx(8'(d), (d * 5) % 12, 1'b0, 1'b0);
    runRx(8'hC3, 4, 1'b1, 1'b0);
    idleCheck(30, "R5 no tx after rx");

    // R8: set flag blocks reception, clearing it starts one
    runRx(8'h96, 0, 1'b0, 1'b1);
    idleCheck(36, "R8 flag blocks reception");
    chk("R8 rx flag held", int'(rxFlag), 1);
    waitSlot(5);
    rxFlagClr = 1'b1;
    @(negedge clk);
    rxFlagClr = 1'b0;
    dataIn = 1'b1;
    m = 0;
    while (1) begin
      act = (m >= 2) && (m <= 9);
      chk("R8 restart clock", int'(shiftClk), int'(!(act && slot >= 4 && slot <= 9)));
      chk("R8 restart flag", int'(rxFlag), int'(m >= 10));
      if (m == 10) begin
        chk("R8 restart byte", int'(bufRdData), 8'hFF);
        break;
      end
      @(negedge clk);
      if (slot == 0) m++;
    end
    rxEnable = 1'b0;
    idleCheck(24, "R10 idle at end");

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(150000 * 8);
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule